// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block maps a physical byte address onto a DRAM rank for a memory controller with two channels of four ranks each. Software programs, for each channel, one cumulative upper-boundary byte per rank, counted in 32 MiB units. It also programs one attribute byte per pair of ranks, which holds a page-size code for each rank of the pair. From these registers the block decides whether the two channels are populated identically, and so interleaved, or whether they must be stacked one after the other as asymmetric memory. It also reports the total installed size.

An address is presented with a valid strobe. One clock later the block reports whether the address hit a populated rank, which channel and rank it hit, the current interleave decision, and the total memory size. Register writes and address lookups may occur in the same cycle. A lookup always uses the register contents from before the write in that cycle.

Top module: `rank_boundary_decoder`

## Requirements
- R1: Register write port: `wr_addr` 0..7 writes the boundary byte of channel `wr_addr/4`, rank `wr_addr%4`. `wr_addr` 8..11 writes the attribute byte of channel `(wr_addr-8)/2`, rank pair `(wr_addr-8)%2`. Writes to 12..15 change nothing. Reset clears every register to zero.
- R2: In an attribute byte, bits 2:0 give the code of the even rank of the pair and bits 6:4 give the code of the odd rank. Bits 3 and 7 are ignored. Codes 3'b010, 3'b011 and 3'b100 mean populated. Code 3'b000 (empty) and the codes 001, 101, 110 and 111 exclude the rank from any match.
- R3: A rank whose effective boundary equals that of the rank before it spans no addresses and is never selected.
- R4: The interleaved flag is 1 exactly when every rank code of channel 0 equals the matching code of channel 1 and every boundary byte of channel 0 equals the matching byte of channel 1.
- R5: When interleaved, the effective boundary of rank r is twice the channel-0 boundary byte. The reported channel is address bit 12. Channel-1 registers only take part in the interleave decision.
- R6: When not interleaved, channel-0 ranks occupy the map from 0 up to channel-0 boundary 3. Channel-1 rank r ends at channel-0 boundary 3 plus channel-1 boundary r. The reported channel is 0 for the first four ranks and 1 for the rest.
- R7: If no populated rank contains the address, `miss` is 1 and `hit` is 0, and rank and channel read 0. This includes every address at or above the total size.
- R8: `mem_total` (32 MiB units) is twice channel-0 boundary 3 when interleaved. Otherwise it is the sum of both channels' boundary 3.
- R9: All outputs are registered. `res_valid`, `hit` and `miss` follow `addr_valid` from the previous clock. `hit` and `miss` are both 0 when no lookup was requested.
- R10: Rank r contains address bits [35:25] when the previous rank's effective boundary (0 for the first rank) is at or below that value and the rank's own effective boundary is above it. The lowest such populated rank is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 8 | Register write data |
| addr_valid | input | 1 | Lookup request |
| addr | input | 36 | Physical byte address |
| res_valid | output | 1 | Lookup result valid |
| hit | output | 1 | Address falls in a populated rank |
| miss | output | 1 | Lookup found no rank |
| res_chan | output | 1 | Channel of the hit |
| res_rank | output | 2 | Rank within the channel |
| ilv_flag | output | 1 | Channels are interleaved |
| mem_total | output | 9 | Total memory in 32 MiB units |

## Verification
A corrupted boundary or attribute register shows at the ports on the next lookup. It appears as a shifted rank edge, a wrong channel, or a spurious miss, and it is also visible in `mem_total` and `ilv_flag` one clock after the bad write. A wrong interleave decision flips the channel source and halves or stacks the address map, so a sweep across the rank edges exposes it within a few lookups. A fault in the range comparison or the priority logic shows as a wrong rank exactly at a boundary value or at an empty rank.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int ATTR_W = 3;
  typedef logic [ATTR_W-1:0] rank_code_t;

  localparam rank_code_t CODE_EMPTY = 3'b000;
  localparam rank_code_t CODE_PG4K  = 3'b010;
  localparam rank_code_t CODE_PG8K  = 3'b011;
  localparam rank_code_t CODE_PG16K = 3'b100;

  function automatic logic code_populated(input rank_code_t c);
    return (c == CODE_PG4K) || (c == CODE_PG8K) || (c == CODE_PG16K);
  endfunction
endpackage

// File: rtl/rbd_regfile.sv
module rbd_regfile #(
  parameter int RANKS  = 4,
  parameter int BND_W  = 8,
  parameter int REG_AW = 4
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          wr_en,
  input  logic [REG_AW-1:0]                             wr_addr,
  input  logic [BND_W-1:0]                              wr_data,
  output logic [1:0][RANKS-1:0][BND_W-1:0]              bnd_q,
  output logic [1:0][RANKS-1:0][rbd_pkg::ATTR_W-1:0]    code_q
);
  localparam int AW        = rbd_pkg::ATTR_W;
  localparam int PAIRS     = RANKS / 2;
  localparam int CODE_BASE = 2 * RANKS;
  localparam int NREG      = CODE_BASE + 2 * PAIRS;
  localparam int ODD_LSB   = BND_W / 2;

  logic unused_rsvd;
  assign unused_rsvd = ^{wr_data[ODD_LSB-1:AW], wr_data[BND_W-1:ODD_LSB+AW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      bnd_q  <= '0;
      code_q <= '0;
    end else if (wr_en) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int r = 0; r < RANKS; r++) begin
          if (int'(wr_addr) == ch * RANKS + r) bnd_q[ch][r] <= wr_data;
        end
        for (int p = 0; p < PAIRS; p++) begin
          if (int'(wr_addr) == CODE_BASE + ch * PAIRS + p) begin
            code_q[ch][2*p]   <= wr_data[AW-1:0];
            code_q[ch][2*p+1] <= wr_data[ODD_LSB +: AW];
          end
        end
      end
    end
  end

  // R1: idle cycles and out-of-range indices leave every register untouched
  assert_regs_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || int'(wr_addr) >= NREG) |=> ($stable(bnd_q) && $stable(code_q)));
endmodule

// File: rtl/rbd_ilv_detect.sv
module rbd_ilv_detect #(
  parameter int RANKS = 4,
  parameter int BND_W = 8
) (
  input  logic [1:0][RANKS-1:0][BND_W-1:0]           bnd,
  input  logic [1:0][RANKS-1:0][rbd_pkg::ATTR_W-1:0] code,
  output logic                                       ilv
);
  // R4: identical population on both channels enables interleave
  assign ilv = (code[0] == code[1]) && (bnd[0] == bnd[1]);
endmodule

// File: rtl/rbd_rank_match.sv
module rbd_rank_match #(
  parameter int RANKS  = 4,
  parameter int BND_W  = 8,
  parameter int CMP_W  = 11,
  parameter int SLOT_W = 3
) (
  input  logic                                       ilv,
  input  logic [CMP_W-1:0]                           a_hi,
  input  logic [1:0][RANKS-1:0][BND_W-1:0]           bnd,
  input  logic [1:0][RANKS-1:0][rbd_pkg::ATTR_W-1:0] code,
  output logic                                       match,
  output logic [SLOT_W-1:0]                          slot,
  output logic [BND_W:0]                             total
);
  localparam int NSLOT = 2 * RANKS;

  logic [NSLOT-1:0][CMP_W-1:0] upper;
  logic [NSLOT-1:0][CMP_W-1:0] lower;
  logic [NSLOT-1:0]            cand;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int CH = s / RANKS;
    localparam int RK = s % RANKS;
    logic en;
    if (CH == 0) begin : g_c0
      assign upper[s] = ilv ? CMP_W'({bnd[0][RK], 1'b0}) : CMP_W'(bnd[0][RK]);
      assign en       = rbd_pkg::code_populated(code[0][RK]);
    end else begin : g_c1
      assign upper[s] = CMP_W'(bnd[0][RANKS-1]) + CMP_W'(bnd[1][RK]);
      assign en       = rbd_pkg::code_populated(code[1][RK]) && !ilv;
    end
    if (s == 0) begin : g_first
      assign lower[s] = '0;
    end else begin : g_next
      assign lower[s] = upper[s-1];
    end
    assign cand[s] = en && (lower[s] <= a_hi) && (a_hi < upper[s]);
  end

  always_comb begin
    match = |cand;
    slot  = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (cand[s]) slot = SLOT_W'(s);
    end
  end

  assign total = ilv ? {bnd[0][RANKS-1], 1'b0}
                     : ({1'b0, bnd[0][RANKS-1]} + {1'b0, bnd[1][RANKS-1]});
endmodule

// File: rtl/rank_boundary_decoder.sv
module rank_boundary_decoder #(
  parameter int ADDR_W     = 36,
  parameter int GRAN_SHIFT = 25,
  parameter int RANKS      = 4,
  parameter int BND_W      = 8,
  parameter int ILV_BIT    = 12,
  parameter int REG_AW     = 4,
  localparam int RANK_W    = $clog2(RANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BND_W-1:0]  wr_data,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              res_valid,
  output logic              hit,
  output logic              miss,
  output logic              res_chan,
  output logic [RANK_W-1:0] res_rank,
  output logic              ilv_flag,
  output logic [BND_W:0]    mem_total
);
  localparam int HI_W   = ADDR_W - GRAN_SHIFT;
  localparam int CMP_W  = (HI_W > BND_W + 1) ? HI_W : BND_W + 1;
  localparam int SLOT_W = RANK_W + 1;

  logic [1:0][RANKS-1:0][BND_W-1:0]           bnd;
  logic [1:0][RANKS-1:0][rbd_pkg::ATTR_W-1:0] code;
  logic                                       ilv;
  logic                                       match;
  logic [SLOT_W-1:0]                          slot;
  logic [BND_W:0]                             total;
  logic [HI_W-1:0]                            a_hi;
  logic                                       unused_low;

  assign a_hi       = addr[ADDR_W-1:GRAN_SHIFT];
  assign unused_low = ^addr[GRAN_SHIFT-1:0];

  rbd_regfile #(.RANKS(RANKS), .BND_W(BND_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bnd_q(bnd), .code_q(code));

  rbd_ilv_detect #(.RANKS(RANKS), .BND_W(BND_W)) u_ilv (
    .bnd(bnd), .code(code), .ilv(ilv));

  rbd_rank_match #(.RANKS(RANKS), .BND_W(BND_W), .CMP_W(CMP_W), .SLOT_W(SLOT_W)) u_match (
    .ilv(ilv), .a_hi(CMP_W'(a_hi)), .bnd(bnd), .code(code),
    .match(match), .slot(slot), .total(total));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      hit       <= 1'b0;
      miss      <= 1'b0;
      res_chan  <= 1'b0;
      res_rank  <= '0;
      ilv_flag  <= 1'b0;
      mem_total <= '0;
    end else begin
      res_valid <= addr_valid;
      hit       <= addr_valid && match;
      miss      <= addr_valid && !match;
      if (addr_valid && match) begin
        res_chan <= ilv ? addr[ILV_BIT] : slot[RANK_W];
        res_rank <= slot[RANK_W-1:0];
      end else begin
        res_chan <= 1'b0;
        res_rank <= '0;
      end
      ilv_flag  <= ilv;
      mem_total <= total;
    end
  end

  // R9: one-cycle registered lookup
  assert_lookup_latency_R9: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> res_valid);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |=> (!res_valid && !hit && !miss));
  // R7: a hit can never lie at or above the installed total
  assert_hit_below_total_R7: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(a_hi) < HI_W'(mem_total)));
  // R5: interleaved hits take their channel from the address
  assert_ilv_channel_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && ilv_flag) |-> (res_chan == $past(addr[ILV_BIT])));
endmodule

// File: tb/rank_boundary_decoder_tb.sv
module rank_boundary_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        addr_valid = 1'b0;
  logic [35:0] addr = '0;
  logic        res_valid, hit, miss, res_chan, ilv_flag;
  logic [1:0]  res_rank;
  logic [8:0]  mem_total;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  int mb[2][4];
  int mc[2][4];

  always #4 clk = ~clk;

  rank_boundary_decoder dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .addr_valid(addr_valid), .addr(addr), .res_valid(res_valid), .hit(hit),
    .miss(miss), .res_chan(res_chan), .res_rank(res_rank), .ilv_flag(ilv_flag),
    .mem_total(mem_total));

  task automatic check(input int act, input int exp, input string req,
                       input string what, input string tag);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, tag, what, act, exp);
    end
  endtask

  function automatic bit ok_code(input int c);
    return (c == 2) || (c == 3) || (c == 4);
  endfunction

  function automatic bit model_ilv();
    for (int ch = 0; ch < 4; ch++)
      if (mb[0][ch] != mb[1][ch] || mc[0][ch] != mc[1][ch]) return 0;
    return 1;
  endfunction

  task automatic cyc(input bit av, input logic [35:0] a, input bit we,
                     input int wa, input int wd, input string tag);
    bit il, e_hit, e_chan;
    int e_rank, e_total, ahi, prev, up;
    addr_valid = av; addr = a; wr_en = we; wr_addr = wa[3:0]; wr_data = wd[7:0];
    il = model_ilv();
    e_total = il ? 2 * mb[0][3] : mb[0][3] + mb[1][3];
    ahi = int'(a[35:25]);
    e_hit = 0; e_chan = 0; e_rank = 0; prev = 0;
    for (int k = 0; k < 8; k++) begin
      int ch, r;
      ch = k / 4; r = k % 4;
      if (ch == 0) up = il ? 2 * mb[0][r] : mb[0][r];
      else         up = mb[0][3] + mb[1][r];
      if (!e_hit && av && ok_code(mc[ch][r]) && !(il && ch == 1) &&
          prev <= ahi && ahi < up) begin
        e_hit = 1; e_rank = r; e_chan = il ? a[12] : ch[0];
      end
      prev = up;
    end
    @(posedge clk);
    if (we) begin
      if (wa < 8) mb[wa/4][wa%4] = wd & 255;
      else if (wa < 12) begin
        mc[(wa-8)/2][2*((wa-8)%2)]   = wd & 7;
        mc[(wa-8)/2][2*((wa-8)%2)+1] = (wd >> 4) & 7;
      end
    end
    @(negedge clk);
    check(res_valid, av, "R9", "res_valid", tag);
    check(hit, e_hit, "R10", "hit", tag);
    check(miss, av && !e_hit, "R7", "miss", tag);
    check(res_rank, e_rank, "R10", "rank", tag);
    check(res_chan, e_chan, il ? "R5" : "R6", "chan", tag);
    check(ilv_flag, il, "R4", "ilv_flag", tag);
    check(mem_total, e_total, "R8", "mem_total", tag);
  endtask

  function automatic logic [35:0] mk_addr(input int ahi, input int salt);
    logic [24:0] lo;
    lo = 25'((ahi * 32'h0002F1D3) ^ (salt * 32'h00001A35));
    return {11'(ahi), lo};
  endfunction

  task automatic wr(input int wa, input int wd, input string tag);
    cyc(1, mk_addr(wa, wd), 1, wa, wd, tag);
  endtask

  task automatic sweep(input int lo, input int hi, input string tag);
    for (int v = lo; v <= hi; v++) cyc(1, mk_addr(v, v + lo), 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R9 watchdog expired: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int r = 0; r < 4; r++) begin mb[c][r] = 0; mc[c][r] = 0; end
    addr_valid = 1; addr = mk_addr(3, 1);
    repeat (3) @(negedge clk);
    // R9 / R1: reset state
    check(res_valid, 0, "R9", "reset res_valid", "reset");
    check(hit, 0, "R9", "reset hit", "reset");
    check(mem_total, 0, "R1", "reset mem_total", "reset");
    rst = 0;
    sweep(0, 3, "R1 cleared regs miss");
    // symmetric population; ch1 codes carry reserved bits 3 and 7 (R2)
    wr(0, 4, "R1"); wr(1, 8, "R1"); wr(2, 8, "R3"); wr(3, 16, "R1");
    wr(4, 4, "R1"); wr(5, 8, "R1"); wr(6, 8, "R3"); wr(7, 16, "R1");
    wr(8, 8'h32, "R2"); wr(9, 8'h24, "R2");
    wr(10, 8'hBA, "R2"); wr(11, 8'hA4, "R2");
    sweep(0, 36, "R5 interleaved map, R3 empty rank");
    // out-of-range register indices are ignored
    for (int k = 12; k < 16; k++) wr(k, 8'hFF, "R1 ignored index");
    sweep(14, 18, "R1 after ignored writes");
    // asymmetric boundaries
    wr(7, 12, "R4");
    sweep(0, 30, "R6 stacked map");
    // reserved odd code on ch0 rank1, then other reserved/empty codes
    wr(8, 8'h12, "R2");
    sweep(0, 10, "R2 reserved code 001");
    wr(8, 8'h52, "R2"); sweep(3, 9, "R2 reserved code 101");
    wr(8, 8'h76, "R2"); sweep(0, 9, "R2 codes 110/111");
    wr(8, 8'h02, "R2"); sweep(3, 9, "R2 empty code");
    // equal boundaries but differing codes
    wr(7, 16, "R4"); wr(8, 8'h32, "R4");
    sweep(0, 3, "R4 back to interleave");
    wr(11, 8'h34, "R4");
    sweep(0, 34, "R4 code mismatch stacks channels");
    // no lookups: outputs stay quiet
    for (int k = 0; k < 4; k++) cyc(0, mk_addr(2, k), 0, 0, 0, "R9 idle");
    cyc(1, mk_addr(40, 0), 0, 0, 0, "R7 above total");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule